// File: doc/BRIEF.md
# PWM Compare Action Generator

This block turns the running value of an external PWM time-base counter into one PWM output level. The counter's current value, its direction of travel and its period arrive as inputs. The block matches them against four timing events: the count reaching zero, the count reaching the period, and the count matching each of two 16-bit thresholds, A and B. A 20-bit action word holds a 2-bit action code for every event, with separate fields for up-counting and for down-counting. The action code of the winning event then sets, clears, inverts or keeps the output.

Each threshold is double-buffered. A write lands in a shadow register. The value moves into the active register, which is the one the comparators use, either at once or at a selected counter boundary. The boundary can be zero, the period, or either one. Software drives a small register write port to load the action word, the two thresholds and the update methods. The two active thresholds can be read back as outputs, so the load policy can be observed.

The output stage is a two-state machine with states OUT_LOW and OUT_HIGH. Its transitions are DRIVE_HI, DRIVE_LO, FLIP and HOLD. Each threshold loader is also a two-state machine. State SH_IDLE means the active value is current. State SH_PEND means a newer value waits in the shadow register. Its transitions are POST (a write moves it from SH_IDLE to SH_PEND), COMMIT (a load event moves it from SH_PEND to SH_IDLE), REPOST (a write while pending stays in SH_PEND) and DIRECT (a write with the immediate method, which goes to SH_IDLE).

Top module: `pwm_action_gen`

## Requirements
- R1: While reset is held, and on release, `pwm_out` is low and both active thresholds read 0. The action word and both update methods are also 0.
- R2: An action code sets `pwm_out` at the first rising edge at which its event is present. The codes are: 0 keeps the level, 1 drives it low, 2 drives it high and 3 inverts it.
- R3: Action word fields are 2 bits wide at these bit offsets. Up-count: zero 0, period 2, threshold A 4, threshold B 6. Down-count: zero 12, period 14, threshold A 16, threshold B 18. Only the fields for the direction on `base_up` (1 = up) are used.
- R4: When several events are present in one cycle, only the highest one present acts, even if its code is 0. The order from highest is threshold B, threshold A, period, zero.
- R5: Write addresses are: 0 action word, 1 threshold A, 2 threshold B, 3 update methods (bits 1:0 for A, bits 3:2 for B). With method 0, a threshold write shows on its active output after the same rising edge.
- R6: With method bit 0 set, a pending threshold moves to active at the edge where `base_count` is 0, in either direction. Period matches do not load it unless bit 1 is also set.
- R7: With method bit 1 set, a pending threshold loads at the edge where `base_count` equals `base_period`. With both bits set, either boundary loads it.
- R8: A threshold write in the same cycle as a load event does not take part in that load. The earlier shadow value is loaded, and the new value waits for the next load event.
- R9: Comparisons use only the active thresholds. A value still waiting in the shadow register causes no match.
- R10: With an up-counting base of period P and actions "zero: high, up A: low", the output is high for A of every P+1 cycles. It is high for none of them when A is 0.
- R11: With an up-down base and actions "down A: high, up A: low", the output is high for 2·A consecutive cycles, centred on the zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_count | input | 16 | Current time-base count |
| base_up | input | 1 | 1 when the time base counts up, 0 when down |
| base_period | input | 16 | Period of the time base |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (see R5) |
| cfg_wdata | input | 20 | Register write data |
| pwm_out | output | 1 | PWM output level |
| thr_a_q | output | 16 | Active threshold A |
| thr_b_q | output | 16 | Active threshold B |

## Verification
Every result is due after exactly one rising edge. An event present at an edge decides `pwm_out` after that edge. A load event or a direct write updates `thr_a_q` or `thr_b_q` after that same edge. A pending value therefore first affects comparisons in the following cycle. Each scenario drives the counter and write inputs 1 ns after a rising edge, waits for the next rising edge, and samples 1 ns later. Every sample therefore reflects exactly one edge of logic.

// File: rtl/pwm_act_pkg.sv
package pwm_act_pkg;

    localparam int ACT_WORD_W = 20;
    localparam int N_EVENTS   = 4;

    // event index: 0 zero, 1 period, 2 threshold A, 3 threshold B (also priority, 3 highest)
    localparam int UP_OFS [N_EVENTS] = '{0, 2, 4, 6};
    localparam int DN_OFS [N_EVENTS] = '{12, 14, 16, 18};

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_FLIP = 2'd3
    } act_code_t;

    typedef enum logic [1:0] {
        ADDR_ACTION = 2'd0,
        ADDR_THR_A  = 2'd1,
        ADDR_THR_B  = 2'd2,
        ADDR_METHOD = 2'd3
    } cfg_addr_t;

endpackage

// File: rtl/pwm_shadow_cmp.sv
module pwm_shadow_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [1:0]       method,
    input  logic             at_zero,
    input  logic             at_period,
    output logic [CNT_W-1:0] active_q
);
    typedef enum logic {SH_IDLE, SH_PEND} sh_state_t;

    sh_state_t        state_q, state_d;
    logic [CNT_W-1:0] shadow_q;
    logic             immediate;
    logic             load_now;

    assign immediate = (method == 2'b00);
    assign load_now  = immediate | (at_zero & method[0]) | (at_period & method[1]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    // transitions: POST, REPOST, DIRECT, COMMIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE: if (wr_en && !immediate) state_d = SH_PEND;
            SH_PEND: begin
                if (wr_en)         state_d = immediate ? SH_IDLE : SH_PEND;
                else if (load_now) state_d = SH_IDLE;
            end
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en) shadow_q <= wr_val;
            if (wr_en && immediate)
                active_q <= wr_val;
            else if (state_q == SH_PEND && load_now)
                active_q <= shadow_q;
        end
    end
endmodule

// File: rtl/pwm_event_sel.sv
module pwm_event_sel
    import pwm_act_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]      count,
    input  logic                  up,
    input  logic [CNT_W-1:0]      period,
    input  logic [CNT_W-1:0]      thr_a,
    input  logic [CNT_W-1:0]      thr_b,
    input  logic [ACT_WORD_W-1:0] act_word,
    output act_code_t             act
);
    logic [N_EVENTS-1:0] hit;
    logic [1:0]          fld [N_EVENTS];

    assign hit[0] = (count == '0);
    assign hit[1] = (count == period);
    assign hit[2] = (count == thr_a);
    assign hit[3] = (count == thr_b);

    for (genvar i = 0; i < N_EVENTS; i++) begin : g_fld
        assign fld[i] = up ? act_word[UP_OFS[i] +: 2] : act_word[DN_OFS[i] +: 2];
    end

    // fixed priority, highest present event wins even with code 0
    always_comb begin
        if (hit[3])      act = act_code_t'(fld[3]);
        else if (hit[2]) act = act_code_t'(fld[2]);
        else if (hit[1]) act = act_code_t'(fld[1]);
        else if (hit[0]) act = act_code_t'(fld[0]);
        else             act = ACT_HOLD;
    end
endmodule

// File: rtl/pwm_out_fsm.sv
module pwm_out_fsm
    import pwm_act_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  act_code_t act,
    output logic      level
);
    typedef enum logic {OUT_LOW, OUT_HIGH} out_state_t;

    out_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_LOW;
        else        state_q <= state_d;
    end

    // transitions: HOLD, DRIVE_LO, DRIVE_HI, FLIP
    always_comb begin
        unique case (act)
            ACT_HOLD: state_d = state_q;
            ACT_LOW:  state_d = OUT_LOW;
            ACT_HIGH: state_d = OUT_HIGH;
            ACT_FLIP: state_d = (state_q == OUT_HIGH) ? OUT_LOW : OUT_HIGH;
        endcase
    end

    // outputs
    always_comb level = (state_q == OUT_HIGH);
endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
    import pwm_act_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      base_count,
    input  logic                  base_up,
    input  logic [CNT_W-1:0]      base_period,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_addr,
    input  logic [((CNT_W > ACT_WORD_W) ? CNT_W : ACT_WORD_W)-1:0] cfg_wdata,
    output logic                  pwm_out,
    output logic [CNT_W-1:0]      thr_a_q,
    output logic [CNT_W-1:0]      thr_b_q
);
    localparam int WD_W = (CNT_W > ACT_WORD_W) ? CNT_W : ACT_WORD_W;
    localparam int N_THR = 2;

    logic [ACT_WORD_W-1:0] act_q;
    logic [3:0]            meth_q;
    logic                  at_zero, at_period;
    logic [N_THR-1:0]      thr_we;
    logic [CNT_W-1:0]      thr_q [N_THR];
    act_code_t             act;
    cfg_addr_t             addr;

    assign addr      = cfg_addr_t'(cfg_addr);
    assign at_zero   = (base_count == '0);
    assign at_period = (base_count == base_period);
    assign thr_we[0] = cfg_we && (addr == ADDR_THR_A);
    assign thr_we[1] = cfg_we && (addr == ADDR_THR_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            meth_q <= '0;
        end else if (cfg_we) begin
            if (addr == ADDR_ACTION) act_q  <= cfg_wdata[ACT_WORD_W-1:0];
            if (addr == ADDR_METHOD) meth_q <= cfg_wdata[3:0];
        end
    end

    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        pwm_shadow_cmp #(.CNT_W(CNT_W)) u_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (thr_we[t]),
            .wr_val   (cfg_wdata[CNT_W-1:0]),
            .method   (meth_q[2*t +: 2]),
            .at_zero  (at_zero),
            .at_period(at_period),
            .active_q (thr_q[t])
        );
    end

    assign thr_a_q = thr_q[0];
    assign thr_b_q = thr_q[1];

    pwm_event_sel #(.CNT_W(CNT_W)) u_sel (
        .count   (base_count),
        .up      (base_up),
        .period  (base_period),
        .thr_a   (thr_a_q),
        .thr_b   (thr_b_q),
        .act_word(act_q),
        .act     (act)
    );

    pwm_out_fsm u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .act  (act),
        .level(pwm_out)
    );

    logic unused_wd;
    assign unused_wd = ^{1'b0, cfg_wdata[WD_W-1:0]};
endmodule

// File: rtl/pwm_action_gen_chk.sv
module pwm_action_gen_chk #(
    parameter int CNT_W = 16,
    parameter int WD_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] base_count,
    input logic             base_up,
    input logic [CNT_W-1:0] base_period,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [WD_W-1:0]  cfg_wdata,
    input logic             pwm_out,
    input logic [CNT_W-1:0] thr_a_q,
    input logic [CNT_W-1:0] thr_b_q,
    input logic [19:0]      act_q,
    input logic [3:0]       meth_q
);
    logic any_event;
    assign any_event = (base_count == '0) || (base_count == base_period) ||
                       (base_count == thr_a_q) || (base_count == thr_b_q);

    // R2
    out_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwm_out) |-> $past(any_event));

    // R4
    b_high_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_up && base_count == thr_b_q && act_q[7:6] == 2'd2) |=> pwm_out);

    // R4
    b_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_up && base_count == thr_b_q && act_q[7:6] == 2'd1) |=> !pwm_out);

    // R5
    direct_write_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd1 && meth_q[1:0] == 2'b00) |=>
        (thr_a_q == $past(cfg_wdata[CNT_W-1:0])));

    // R6
    thr_a_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(thr_a_q) |-> $past(meth_q[1:0] == 2'b00 ||
            (meth_q[0] && base_count == '0) || (meth_q[1] && base_count == base_period)));

    // R7
    thr_b_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(thr_b_q) |-> $past(meth_q[3:2] == 2'b00 ||
            (meth_q[2] && base_count == '0) || (meth_q[3] && base_count == base_period)));
endmodule

bind pwm_action_gen pwm_action_gen_chk #(.CNT_W(CNT_W), .WD_W(WD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_count (base_count),
    .base_up    (base_up),
    .base_period(base_period),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .pwm_out    (pwm_out),
    .thr_a_q    (thr_a_q),
    .thr_b_q    (thr_b_q),
    .act_q      (act_q),
    .meth_q     (meth_q)
);

// File: tb/pwm_action_gen_bench.sv
`timescale 1ns/1ps
module pwm_action_gen_bench;
    localparam logic [15:0] QUIET = 16'hABCD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base_count = QUIET;
    logic        base_up = 1'b1;
    logic [15:0] base_period = 16'd100;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [19:0] cfg_wdata = '0;
    logic        pwm_out;
    logic [15:0] thr_a_q, thr_b_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_action_gen u_pwm_action_gen (
        .clk(clk), .rst_n(rst_n), .base_count(base_count), .base_up(base_up),
        .base_period(base_period), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pwm_out(pwm_out), .thr_a_q(thr_a_q), .thr_b_q(thr_b_q)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int c, input logic up);
        base_count = 16'(c);
        base_up = up;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 20'(d);
        tick(QUIET, 1'b1);
        cfg_we = 1'b0;
    endtask

    task automatic wr_tick(input int a, input int d, input int c, input logic up);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 20'(d);
        tick(c, up);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check(pwm_out, 0, "R1 out in reset");
        check(thr_a_q, 0, "R1 thr A in reset");
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
        tick(QUIET, 1'b1);
        check(pwm_out, 0, "R1 out after reset");
        check(thr_b_q, 0, "R1 thr B after reset");
    endtask

    task automatic t_codes();
        wr(1, 1000); wr(2, 2000);
        wr(0, 2); tick(0, 1); check(pwm_out, 1, "R2 code 2 high");
        wr(0, 0); tick(0, 1); check(pwm_out, 1, "R2 code 0 holds");
        wr(0, 1); tick(0, 1); check(pwm_out, 0, "R2 code 1 low");
        wr(0, 3); tick(0, 1); check(pwm_out, 1, "R2 code 3 flips up");
        tick(0, 1); check(pwm_out, 0, "R2 code 3 flips down");
    endtask

    task automatic t_offsets();
        wr(1, 10); wr(2, 20);
        wr(0, 1); tick(0, 1); check(pwm_out, 0, "R3 preset low");
        wr(0, 2 << 2);  tick(100, 0); check(pwm_out, 0, "R3 up field ignored down");
        tick(100, 1); check(pwm_out, 1, "R3 up period ofs 2");
        wr(0, 1 << 14); tick(100, 1); check(pwm_out, 1, "R3 down field ignored up");
        tick(100, 0); check(pwm_out, 0, "R3 down period ofs 14");
        wr(0, 2 << 4);  tick(10, 1); check(pwm_out, 1, "R3 up A ofs 4");
        wr(0, 1 << 16); tick(10, 0); check(pwm_out, 0, "R3 down A ofs 16");
        wr(0, 2 << 6);  tick(20, 1); check(pwm_out, 1, "R3 up B ofs 6");
        wr(0, 1 << 18); tick(20, 0); check(pwm_out, 0, "R3 down B ofs 18");
        wr(0, 2 << 12); tick(0, 0);  check(pwm_out, 1, "R3 down zero ofs 12");
    endtask

    task automatic t_priority();
        base_period = 16'd50;
        wr(1, 50); wr(2, 50);
        wr(0, 1); tick(0, 1); check(pwm_out, 0, "R4 preset low");
        wr(0, 'h98); tick(50, 1); check(pwm_out, 1, "R4 B over A and period");
        wr(0, 'h18); tick(50, 1); check(pwm_out, 1, "R4 B code 0 masks A");
        wr(2, 60);   tick(50, 1); check(pwm_out, 0, "R4 A over period");
        wr(1, 70);   tick(50, 1); check(pwm_out, 1, "R4 period acts when alone");
        base_period = 16'd0;
        wr(0, 'h6);  tick(0, 1); check(pwm_out, 0, "R4 period over zero");
        base_period = 16'd100;
    endtask

    task automatic t_immediate();
        wr(3, 0);
        wr(1, 123); check(thr_a_q, 123, "R5 direct A");
        wr(2, 77);  check(thr_b_q, 77, "R5 direct B");
    endtask

    task automatic t_load_zero();
        wr(3, 'b0001);
        wr(1, 300);   check(thr_a_q, 123, "R6 held while pending");
        tick(100, 1); check(thr_a_q, 123, "R6 period does not load");
        tick(0, 0);   check(thr_a_q, 300, "R6 loads at zero down");
        wr(1, 301); tick(0, 1); check(thr_a_q, 301, "R6 loads at zero up");
    endtask

    task automatic t_load_period();
        wr(3, 'b1001);
        wr(2, 400);
        tick(0, 1);   check(thr_b_q, 77, "R7 zero does not load");
        tick(100, 0); check(thr_b_q, 400, "R7 loads at period");
    endtask

    task automatic t_collision();
        wr(1, 500); check(thr_a_q, 301, "R8 pending");
        wr_tick(1, 600, 0, 1); check(thr_a_q, 500, "R8 old shadow loaded");
        tick(0, 1); check(thr_a_q, 600, "R8 new value next zero");
    endtask

    task automatic t_active_only();
        wr(0, 'h12);
        tick(0, 1); check(pwm_out, 1, "R9 preset high");
        wr(1, 20);
        tick(20, 1);  check(pwm_out, 1, "R9 shadow value no match");
        tick(600, 1); check(pwm_out, 0, "R9 active value matches");
        tick(0, 1);   check(thr_a_q, 20, "R9 loaded later");
        wr(3, 'b1011);
        wr(1, 33); tick(100, 1); check(thr_a_q, 33, "R7 both bits, period loads");
    endtask

    task automatic t_up_pwm();
        int hi;
        wr(3, 0); wr(1, 3); wr(2, 1000); wr(0, 'h12);
        base_period = 16'd9;
        for (int p = 0; p < 2; p++) begin
            hi = 0;
            for (int k = 0; k <= 9; k++) begin
                tick(k, 1);
                if (pwm_out) hi++;
            end
            check(hi, 3, "R10 high cycles equal A");
        end
        wr(1, 0);
        hi = 0;
        for (int k = 0; k <= 9; k++) begin
            tick(k, 1);
            if (pwm_out) hi++;
        end
        check(hi, 0, "R10 A=0 gives no high");
    endtask

    task automatic t_updown_pwm();
        int hi;
        wr(1, 3); wr(0, (2 << 16) | (1 << 4));
        base_period = 16'd8;
        for (int p = 0; p < 2; p++) begin
            hi = 0;
            for (int k = 0; k < 8; k++) begin
                tick(k, 1);
                if (pwm_out) hi++;
            end
            for (int k = 8; k > 0; k--) begin
                tick(k, 0);
                if (pwm_out) hi++;
            end
            if (p == 1) check(hi, 6, "R11 centred high time 2A");
        end
        tick(0, 1); check(pwm_out, 1, "R11 high across zero");
        tick(3, 1); check(pwm_out, 0, "R11 low after up match");
    endtask

    initial begin
        t_reset();
        t_codes();
        t_offsets();
        t_priority();
        t_immediate();
        t_load_zero();
        t_load_period();
        t_collision();
        t_active_only();
        t_up_pwm();
        t_updown_pwm();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule